// File: doc/BRIEF.md
# Programmable Tick Timer with Match Modes

This block is a free-running tick counter for a processor core. A 32-bit count register advances once per cycle in which the timer clock enable is high. The low 28 bits of the count are compared with a 28-bit period. On a match the timer acts according to a 2-bit mode: it can restart the count from zero, halt it until software writes the count again, or let it run on. The timer has its own clock enable, so it can keep counting while the rest of the core is gated off in a low-power state.

When a match occurs and the interrupt is enabled, a sticky pending flag is set. The high-priority interrupt request output follows that flag. Software clears the flag by writing a zero to it.

Software sees two registers. The control register has the mode in bits 31:30, the interrupt enable in bit 29, the pending flag in bit 28 and the period in bits 27:0. The count register can always be read. It can be written only when the privilege input shows supervisor mode. How the interrupt request is routed onward is not part of this block.

Top module: `tick_timer_core`

## Requirements
- R1: After reset, the control register and the count register both read zero and the interrupt request is low.
- R2: With mode 0 the count never changes except through an accepted count write, and no match event occurs.
- R3: With a nonzero mode and no halt in force, the count increases by exactly one on each clock in which the tick enable is high. When the tick enable is low, the count holds.
- R4: A match is a counting cycle in which count bits 27:0 equal the period; count bits 31:28 take no part in it. In mode 3 the count goes on past a match, and it wraps from 0xFFFFFFFF to 0.
- R5: In mode 1, the clock edge that sees a match loads the count with zero.
- R6: In mode 2, a match freezes the count at its value. The count then stays frozen, and no further match event occurs, until an accepted count write. Counting then resumes from the written value.
- R7: A match sets the pending flag (control bit 28) only when the interrupt enable (control bit 29) is set. The interrupt request output equals the pending flag.
- R8: A control write with bit 28 = 0 clears the pending flag. A control write with bit 28 = 1 leaves the flag unchanged and never sets it. A match in the same cycle as the write wins over the clear.
- R9: A count write is accepted only while the privilege input is 1 (supervisor). With the privilege input at 0, the write leaves the count untouched.
- R10: An accepted count write takes precedence over counting and over match detection in its cycle. A control write takes effect on the next cycle, so counting in the write cycle uses the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Timer clock enable; one count step per high cycle |
| priv_i | input | 1 | 1 = supervisor, qualifies count writes |
| ctl_wr_i | input | 1 | Write strobe for the control register |
| cnt_wr_i | input | 1 | Write strobe for the count register |
| wdata_i | input | CNT_W (32) | Write data for either register |
| ctl_o | output | PER_W+4 (32) | Control register readback |
| count_o | output | CNT_W (32) | Count register readback |
| irq_o | output | 1 | High-priority interrupt request |

## Verification
The bench builds the block with its default widths: a 32-bit count and a 28-bit period. It keeps most periods and written counts below 16, so that all three match modes fire hundreds of times in the random phase, including collisions between writes, matches and the tick enable. Some written counts carry random upper bits, which checks that bits 31:28 take no part in the compare. A directed case starts just below 0xFFFFFFFF to reach the wrap.

// File: rtl/tt_pkg.sv
`timescale 1ns/1ps
package tt_pkg;
    typedef enum logic [1:0] {
        TT_OFF     = 2'd0,
        TT_RESTART = 2'd1,
        TT_HALT    = 2'd2,
        TT_FREE    = 2'd3
    } tt_mode_e;
endpackage

// File: rtl/tt_compare.sv
`timescale 1ns/1ps
module tt_compare #(
    parameter int PER_W = 28
) (
    input  logic [PER_W-1:0] lhs_i,
    input  logic [PER_W-1:0] rhs_i,
    output logic             eq_o
);
    logic [PER_W-1:0] bit_eq;

    for (genvar b = 0; b < PER_W; b++) begin : g_bit
        assign bit_eq[b] = ~(lhs_i[b] ^ rhs_i[b]);
    end

    assign eq_o = &bit_eq;
endmodule

// File: rtl/tt_step.sv
`timescale 1ns/1ps
module tt_step
    import tt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] count_i,
    input  tt_mode_e         mode_i,
    input  logic             halted_i,
    input  logic             tick_i,
    input  logic             low_eq_i,
    input  logic             wr_ok_i,
    input  logic [CNT_W-1:0] wr_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             halted_o,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic active;

    always_comb begin
        active   = tick_i && (mode_i != TT_OFF) && !halted_i && !wr_ok_i;
        hit_o    = active && low_eq_i;
        count_o  = count_i;
        halted_o = halted_i;
        if (wr_ok_i) begin
            count_o  = wr_val_i;
            halted_o = 1'b0;
        end else if (active) begin
            if (hit_o) begin
                unique case (mode_i)
                    TT_RESTART: count_o = '0;
                    TT_HALT: begin
                        count_o  = count_i;
                        halted_o = 1'b1;
                    end
                    default: count_o = count_i + ONE;
                endcase
            end else begin
                count_o = count_i + ONE;
            end
        end
    end
endmodule

// File: rtl/tick_timer_core.sv
`timescale 1ns/1ps
module tick_timer_core
    import tt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PER_W = 28
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_en_i,
    input  logic               priv_i,
    input  logic               ctl_wr_i,
    input  logic               cnt_wr_i,
    input  logic [CNT_W-1:0]   wdata_i,
    output logic [PER_W+3:0]   ctl_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               irq_o
);
    localparam int REG_W   = PER_W + 4;
    localparam int PEND_B  = PER_W;
    localparam int IE_B    = PER_W + 1;
    localparam int MODE_LO = PER_W + 2;

    typedef struct packed {
        tt_mode_e         mode;
        logic             ie;
        logic             pend;
        logic [PER_W-1:0] period;
        logic [CNT_W-1:0] count;
        logic             halted;
    } tt_state_t;

    tt_state_t st_d, st_q;

    logic             cnt_wr_ok;
    logic             low_eq;
    logic             hit;
    logic [CNT_W-1:0] count_nxt;
    logic             halted_nxt;

    assign cnt_wr_ok = cnt_wr_i && priv_i;

    tt_compare #(.PER_W(PER_W)) i_cmp (
        .lhs_i (st_q.count[PER_W-1:0]),
        .rhs_i (st_q.period),
        .eq_o  (low_eq)
    );

    tt_step #(.CNT_W(CNT_W)) i_step (
        .count_i  (st_q.count),
        .mode_i   (st_q.mode),
        .halted_i (st_q.halted),
        .tick_i   (tick_en_i),
        .low_eq_i (low_eq),
        .wr_ok_i  (cnt_wr_ok),
        .wr_val_i (wdata_i),
        .count_o  (count_nxt),
        .halted_o (halted_nxt),
        .hit_o    (hit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.count  = count_nxt;
        st_d.halted = halted_nxt;
        if (ctl_wr_i) begin
            st_d.mode   = tt_mode_e'(wdata_i[MODE_LO+1:MODE_LO]);
            st_d.ie     = wdata_i[IE_B];
            st_d.period = wdata_i[PER_W-1:0];
            st_d.pend   = st_q.pend && wdata_i[PEND_B];
        end
        if (hit && st_q.ie) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o   = {st_q.mode, st_q.ie, st_q.pend, st_q.period};
    assign count_o = st_q.count;
    assign irq_o   = st_q.pend;

    // R3: one step per enabled tick when nothing else intervenes
    a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_en_i && st_q.mode != TT_OFF && !st_q.halted && !cnt_wr_ok && !low_eq)
        |=> (st_q.count == $past(st_q.count) + {{(CNT_W-1){1'b0}}, 1'b1}));

    // R2: mode 0 keeps the count without a write
    a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == TT_OFF && !cnt_wr_ok) |=> $stable(st_q.count));

    // R5: restart mode returns to zero after a match
    a_r5_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit && st_q.mode == TT_RESTART) |=> (st_q.count == '0));

    // R6: a halted count holds until an accepted write
    a_r6_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.halted && !cnt_wr_ok) |=> $stable(st_q.count));

    // R7: pending only rises while the interrupt is enabled
    a_r7_pend_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.pend) |-> $past(st_q.ie));

    // R8: pending is sticky unless written with zero
    a_r8_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pend && !(ctl_wr_i && !wdata_i[PEND_B])) |=> st_q.pend);

    // R9: a write without privilege does not load the count
    a_r9_priv_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_wr_i && !priv_i && !tick_en_i) |=> $stable(st_q.count));

    initial begin
        a_r9_width_fit: assert (CNT_W >= REG_W);
    end
endmodule

// File: tb/test_tick_timer_core.sv
`timescale 1ns/1ps
module test_tick_timer_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        priv = 1'b0;
    logic        ctl_wr = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] ctl;
    logic [31:0] count;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    logic [1:0]  m_mode;
    logic        m_ie, m_pend, m_halt;
    logic [27:0] m_per;
    logic [31:0] m_cnt;

    always #2 clk = ~clk;

    tick_timer_core i_tick_timer_core (
        .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .priv_i(priv),
        .ctl_wr_i(ctl_wr), .cnt_wr_i(cnt_wr), .wdata_i(wdata),
        .ctl_o(ctl), .count_o(count), .irq_o(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_ctl();
        return {m_mode, m_ie, m_pend, m_per};
    endfunction

    // one cycle: drive at negedge, model the edge, compare at next negedge
    task automatic cyc(logic t, logic p, logic cw, logic kw, logic [31:0] d, string req);
        logic cw_ok, hit, act;
        tick_en = t; priv = p; ctl_wr = cw; cnt_wr = kw; wdata = d;
        cw_ok = kw && p;
        act   = t && m_mode != 2'd0 && !m_halt && !cw_ok;
        hit   = act && (m_cnt[27:0] == m_per);
        @(posedge clk);
        if (cw_ok) begin
            m_cnt = d; m_halt = 1'b0;
        end else if (act) begin
            if (hit && m_mode == 2'd1) m_cnt = '0;
            else if (hit && m_mode == 2'd2) m_halt = 1'b1;
            else m_cnt = m_cnt + 32'd1;
        end
        if (cw) m_pend = m_pend && d[28];
        if (hit && m_ie) m_pend = 1'b1;
        if (cw) begin
            m_mode = d[31:30]; m_ie = d[29]; m_per = d[27:0];
        end
        @(negedge clk);
        check({req, " count"}, count, m_cnt);
        check({req, " ctl"}, ctl, m_ctl());
        check({req, " irq"}, {31'd0, irq}, {31'd0, m_pend});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_mode = 0; m_ie = 0; m_pend = 0; m_halt = 0; m_per = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 count", count, 32'd0);
        check("R1 ctl", ctl, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R2 mode 0 holds
        cyc(1, 0, 0, 0, 0, "R2 idle");
        cyc(1, 1, 0, 1, 32'd7, "R2 write in idle");
        cyc(1, 1, 0, 0, 0, "R2 idle hold");
        check("R2 idle value", count, 32'd7);

        // R3 counting, tick gated
        cyc(1, 1, 1, 0, {2'd3, 1'b0, 1'b0, 28'hFFFFFF}, "R3 set free");
        check("R3 step in ctl write cycle uses old mode", count, 32'd7);
        cyc(1, 1, 0, 0, 0, "R3 step");
        check("R3 after one tick", count, 32'd8);
        cyc(0, 1, 0, 0, 0, "R3 no tick");
        check("R3 hold without tick", count, 32'd8);

        // R9 unprivileged write ignored
        cyc(0, 0, 0, 1, 32'h55, "R9 user write");
        check("R9 user write ignored", count, 32'd8);

        // R4 wrap and upper bits ignored
        cyc(0, 1, 0, 1, 32'hFFFF_FFFE, "R4 preload");
        cyc(1, 1, 0, 0, 0, "R4 inc");
        cyc(1, 1, 0, 0, 0, "R4 wrap");
        check("R4 wrap to zero", count, 32'd0);
        cyc(0, 1, 1, 0, {2'd3, 1'b1, 1'b0, 28'd5}, "R4 set period");
        cyc(0, 1, 0, 1, 32'h7000_0005, "R4 preload upper");
        cyc(1, 1, 0, 0, 0, "R4 match upper ignored");
        check("R7 irq after match with ie", {31'd0, irq}, 32'd1);
        check("R4 continues past match", count, 32'h7000_0006);

        // R8 write 1 keeps, write 0 clears
        cyc(0, 1, 1, 0, {2'd3, 1'b1, 1'b1, 28'd5}, "R8 write one");
        check("R8 pending kept", {31'd0, irq}, 32'd1);
        cyc(0, 1, 1, 0, {2'd3, 1'b0, 1'b0, 28'd5}, "R8 write zero");
        check("R8 pending cleared", {31'd0, irq}, 32'd0);

        // R7 no pending without ie
        cyc(0, 1, 0, 1, 32'd5, "R7 preload");
        cyc(1, 1, 0, 0, 0, "R7 match ie off");
        check("R7 no pending when disabled", {31'd0, irq}, 32'd0);

        // R5 restart
        cyc(0, 1, 1, 0, {2'd1, 1'b1, 1'b0, 28'd2}, "R5 set restart");
        cyc(0, 1, 0, 1, 32'd1, "R5 preload");
        cyc(1, 1, 0, 0, 0, "R5 to period");
        cyc(1, 1, 0, 0, 0, "R5 match");
        check("R5 restarted", count, 32'd0);

        // R6 halt then resume
        cyc(0, 1, 1, 0, {2'd2, 1'b1, 1'b0, 28'd3}, "R6 set halt");
        cyc(1, 1, 0, 0, 0, "R6 step");
        cyc(1, 1, 0, 0, 0, "R6 step");
        cyc(1, 1, 0, 0, 0, "R6 step");
        cyc(1, 1, 0, 0, 0, "R6 match");
        check("R6 frozen at period", count, 32'd3);
        cyc(0, 1, 1, 0, {2'd2, 1'b1, 1'b0, 28'd3}, "R6 clear pend");
        cyc(1, 1, 0, 0, 0, "R6 frozen");
        check("R6 no new match while frozen", {31'd0, irq}, 32'd0);
        // R10 write wins over tick
        cyc(1, 1, 0, 1, 32'd10, "R10 write with tick");
        check("R10 write value kept", count, 32'd10);
        cyc(1, 1, 0, 0, 0, "R6 resume");
        check("R6 resumed", count, 32'd11);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] d;
            logic cw, kw;
            d = {$urandom_range(0, 3) == 0 ? 4'($urandom) : 4'd0, 28'($urandom_range(0, 12))};
            cw = ($urandom_range(0, 19) == 0);
            kw = ($urandom_range(0, 9) == 0);
            if (cw) d = {2'($urandom), 1'($urandom), 1'($urandom), 28'($urandom_range(0, 12))};
            cyc($urandom_range(0, 4) != 0, 1'($urandom), cw, kw, d, "R4 R5 R6 R7 R8 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule